// File: doc/BRIEF.md
# Register Write-Enable Protection Controller

This block decides whether a write reaches a small bank of nonvolatile control registers or a 2048-byte memory array. A serial bus engine upstream decodes the bus into one-cycle events: transaction start, transaction stop, a target selection with a byte address, data bytes, and status reads. For each data byte, the block decides whether to accept it and acknowledge it. An accepted byte is forwarded as a write strobe. When a transaction carrying accepted control or array bytes reaches its stop, the block issues a commit pulse to the nonvolatile write engine. It then holds a busy flag until the engine returns a done pulse.

Writes are gated by a status register with two volatile enables: a general write enable and a register-write enable. Control-register writes need a two-step unlock: write 0x02, then write 0x06. Each completed nonvolatile cycle clears the register-write enable again. Array writes need only the general enable. They are also checked against a three-bit block-protect code supplied by the control-register bank. The status register also carries a read-only power-fail flag. This flag is loaded at reset from a cold-boot indication and is cleared by the first accepted write to a defined control register.

Top module: `wrprot_ctrl`

## Requirements
- R1: After reset, both enables are clear, the busy flag and every strobe are low, and the power-fail flag equals `cold_boot` sampled during reset.
- R2: The status byte has bit 0 = power-fail, bit 1 = write enable, and bit 2 = register-write enable. A status write of 0x02 sets the write enable and clears the register-write enable. A status write of 0x06 sets the write enable, and sets the register-write enable only if the write enable was already set. Both take effect at the stop edge, and neither starts a nonvolatile cycle.
- R3: A status write of 0x00 clears both enables at stop. Any other status value is not acknowledged and changes nothing. Only the first data byte of a status transaction is acknowledged. A start that arrives in place of a stop discards the pending status change.
- R4: A byte to the control target (target code 1) is acknowledged only when both enables are set and no nonvolatile cycle is busy. At most 8 bytes per transaction are acknowledged. The byte address increments after every data byte.
- R5: Accepted control bytes to addresses below 20 raise `wr_stb` with `wr_to_ctrl` high. Accepted control bytes to higher addresses are acknowledged but raise no strobe.
- R6: A stop ending a transaction with at least one accepted control or array byte pulses `nv_start` for one cycle and sets `nv_busy`. A start that arrives in place of that stop issues no commit and leaves the register-write enable set.
- R7: `nv_done` clears `nv_busy` and the register-write enable. The write enable is kept.
- R8: While `nv_busy` is high, no data byte to any target is acknowledged.
- R9: A status read (`bus_rd`) returns the status byte on `rd_data` one cycle later, with `rd_vld` high. Bits 3 to 7 are always zero. A read between the unlock steps does not disturb the enables.
- R10: The power-fail flag is cleared by an accepted control byte to a defined address and by nothing else except reset.
- R11: A byte to the array target (target code 2) is acknowledged and strobed only with the write enable set, no busy cycle, and an address outside the protected range. The protected ranges by code are: 0 and 1 none; 2 600h-7FFh; 3 400h-7FFh; 4 all; 5 000h-03Fh; 6 000h-07Fh; 7 000h-0FFh.
- R12: Bytes sent with no target selected (target code 3, or no address event since start) are never acknowledged. Status is target code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cold_boot | input | 1 | Power-fail flag value loaded during reset |
| bus_start | input | 1 | Transaction start event |
| bus_stop | input | 1 | Transaction stop event |
| bus_addr_vld | input | 1 | Target and address event |
| bus_tgt | input | 2 | Target code: 0 status, 1 control, 2 array, 3 none |
| bus_addr | input | 11 | Starting byte address |
| bus_wr_vld | input | 1 | Data byte event |
| bus_wr_data | input | 8 | Data byte |
| bus_rd | input | 1 | Status read event |
| nv_done | input | 1 | Nonvolatile cycle complete pulse |
| bp_code | input | 3 | Block-protect code |
| byte_ack | output | 1 | Data byte accepted |
| wr_stb | output | 1 | Write strobe for an accepted byte |
| wr_to_ctrl | output | 1 | Strobe targets control registers (else array) |
| wr_addr | output | 11 | Address of the strobed byte |
| wr_data | output | 8 | Data of the strobed byte |
| nv_start | output | 1 | Nonvolatile commit pulse |
| nv_busy | output | 1 | Nonvolatile cycle in progress |
| stat_q | output | 8 | Live status byte |
| rd_vld | output | 1 | Read data valid |
| rd_data | output | 8 | Status byte returned by a read |

## Verification
The unlock path is exercised with several orderings. These are 0x06 without a prior 0x02, the proper 0x02 then 0x06 sequence with a read in between, an illegal status value, and a status write ended by a restart instead of a stop. Together they separate a correct sequence check from a simple bit copy. Control bursts start just below the defined-address limit and run past the 8-byte cap, which splits acknowledgement from strobing. One burst ends in an abort and another in a commit, followed by traffic during busy. Array writes are swept over every protect code at the edges of each range, plus a burst crossing a range boundary. This separates off-by-one range decoding from correct decoding.

// File: rtl/wrprot_pkg.sv
package wrprot_pkg;
  typedef enum logic [1:0] {
    TGT_STAT = 2'd0,
    TGT_CTRL = 2'd1,
    TGT_ARR  = 2'd2,
    TGT_NONE = 2'd3
  } tgt_e;

  typedef enum logic [1:0] {
    PEND_NONE = 2'd0,
    PEND_CLR  = 2'd1,
    PEND_WEL  = 2'd2,
    PEND_BOTH = 2'd3
  } pend_e;

  localparam logic [7:0] STAT_CLR  = 8'h00;
  localparam logic [7:0] STAT_WEL  = 8'h02;
  localparam logic [7:0] STAT_BOTH = 8'h06;
endpackage

// File: rtl/wrprot_guard.sv
module wrprot_guard #(
  parameter int AW = 11
) (
  input  logic [2:0]    bp_code,
  input  logic [AW-1:0] addr,
  output logic          prot
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] LIM_Q3  = (AW+1)'(DEPTH - DEPTH / 4);
  localparam logic [AW:0] LIM_H   = (AW+1)'(DEPTH / 2);
  localparam logic [AW:0] LIM_P1  = (AW+1)'(DEPTH / 32);
  localparam logic [AW:0] LIM_P2  = (AW+1)'(DEPTH / 16);
  localparam logic [AW:0] LIM_P4  = (AW+1)'(DEPTH / 8);

  logic [AW:0] a_ext;
  assign a_ext = {1'b0, addr};

  always_comb begin
    unique case (bp_code)
      3'd2:    prot = (a_ext >= LIM_Q3);
      3'd3:    prot = (a_ext >= LIM_H);
      3'd4:    prot = 1'b1;
      3'd5:    prot = (a_ext < LIM_P1);
      3'd6:    prot = (a_ext < LIM_P2);
      3'd7:    prot = (a_ext < LIM_P4);
      default: prot = 1'b0;
    endcase
  end
endmodule

// File: rtl/wrprot_latch.sv
module wrprot_latch
  import wrprot_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  cold_boot,
  input  logic  apply,
  input  pend_e pend,
  input  logic  nv_done,
  input  logic  pf_clr,
  output logic  wel,
  output logic  rwel,
  output logic  pf
);
  always_ff @(posedge clk) begin
    if (rst) begin
      wel  <= 1'b0;
      rwel <= 1'b0;
      pf   <= cold_boot;
    end else begin
      if (apply) begin
        unique case (pend)
          PEND_CLR:  begin wel <= 1'b0; rwel <= 1'b0; end
          PEND_WEL:  begin wel <= 1'b1; rwel <= 1'b0; end
          PEND_BOTH: begin wel <= 1'b1; rwel <= wel;  end
          default:   ;
        endcase
      end
      if (nv_done) rwel <= 1'b0;
      if (pf_clr)  pf   <= 1'b0;
    end
  end

  assert_rwel_needs_wel_R2: assert property (@(posedge clk) disable iff (rst)
    rwel |-> wel);
  assert_wel_rises_at_stop_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(wel) |-> $past(apply));
  assert_done_drops_rwel_R7: assert property (@(posedge clk) disable iff (rst)
    nv_done |=> !rwel);
  assert_pf_never_sets_R10: assert property (@(posedge clk) disable iff (rst)
    !$rose(pf));
endmodule

// File: rtl/wrprot_xfer.sv
module wrprot_xfer
  import wrprot_pkg::*;
#(
  parameter int AW        = 11,
  parameter int CTRL_DEF  = 20,
  parameter int MAX_BURST = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_start,
  input  logic          bus_stop,
  input  logic          bus_addr_vld,
  input  logic [1:0]    bus_tgt,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr_vld,
  input  logic [7:0]    bus_wr_data,
  input  logic          nv_done,
  input  logic          wel,
  input  logic          rwel,
  input  logic          prot,
  output logic [AW-1:0] cur_addr,
  output logic          apply,
  output pend_e         pend,
  output logic          pf_clr,
  output logic          byte_ack,
  output logic          wr_stb,
  output logic          wr_to_ctrl,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          nv_start,
  output logic          nv_busy
);
  localparam int CW = $clog2(MAX_BURST + 1);
  localparam logic [CW-1:0]  BURST_LIM = CW'(MAX_BURST);
  localparam logic [AW:0]    DEF_LIM   = (AW+1)'(CTRL_DEF);

  logic          in_txn;
  tgt_e          sel;
  logic [CW-1:0] cnt;
  logic          any_nv;
  logic          byte_ok;
  logic          ctrl_def;
  logic          do_byte;
  pend_e         pend_dec;

  assign ctrl_def = ({1'b0, cur_addr} < DEF_LIM);
  assign do_byte  = bus_wr_vld && in_txn && !bus_start && !bus_stop && !bus_addr_vld;
  assign apply    = bus_stop && !bus_start && in_txn;

  always_comb begin
    unique case (bus_wr_data)
      STAT_CLR:  pend_dec = PEND_CLR;
      STAT_WEL:  pend_dec = PEND_WEL;
      STAT_BOTH: pend_dec = PEND_BOTH;
      default:   pend_dec = PEND_NONE;
    endcase
  end

  always_comb begin
    unique case (sel)
      TGT_STAT: byte_ok = !nv_busy && (cnt == '0) && (pend_dec != PEND_NONE);
      TGT_CTRL: byte_ok = !nv_busy && wel && rwel && (cnt < BURST_LIM);
      TGT_ARR:  byte_ok = !nv_busy && wel && !prot;
      default:  byte_ok = 1'b0;
    endcase
  end

  assign pf_clr = do_byte && byte_ok && (sel == TGT_CTRL) && ctrl_def;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_txn     <= 1'b0;
      sel        <= TGT_NONE;
      cnt        <= '0;
      any_nv     <= 1'b0;
      pend       <= PEND_NONE;
      cur_addr   <= '0;
      byte_ack   <= 1'b0;
      wr_stb     <= 1'b0;
      wr_to_ctrl <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
      nv_start   <= 1'b0;
      nv_busy    <= 1'b0;
    end else begin
      byte_ack <= 1'b0;
      wr_stb   <= 1'b0;
      nv_start <= 1'b0;
      if (nv_done) nv_busy <= 1'b0;
      if (bus_start) begin
        in_txn <= 1'b1;
        sel    <= TGT_NONE;
        cnt    <= '0;
        any_nv <= 1'b0;
        pend   <= PEND_NONE;
      end else if (bus_stop) begin
        if (in_txn && any_nv) begin
          nv_start <= 1'b1;
          nv_busy  <= 1'b1;
        end
        in_txn <= 1'b0;
        sel    <= TGT_NONE;
        any_nv <= 1'b0;
        pend   <= PEND_NONE;
      end else if (bus_addr_vld && in_txn) begin
        sel      <= tgt_e'(bus_tgt);
        cur_addr <= bus_addr;
        cnt      <= '0;
      end else if (do_byte) begin
        cur_addr <= cur_addr + 1'b1;
        if (byte_ok) begin
          byte_ack   <= 1'b1;
          cnt        <= cnt + 1'b1;
          wr_to_ctrl <= (sel == TGT_CTRL);
          wr_addr    <= cur_addr;
          wr_data    <= bus_wr_data;
          unique case (sel)
            TGT_STAT: pend <= pend_dec;
            TGT_CTRL: begin any_nv <= 1'b1; wr_stb <= ctrl_def; end
            TGT_ARR:  begin any_nv <= 1'b1; wr_stb <= 1'b1; end
            default:  ;
          endcase
        end
      end
    end
  end

  assert_no_ack_when_busy_R8: assert property (@(posedge clk) disable iff (rst)
    byte_ack |-> !$past(nv_busy));
  assert_ctrl_needs_unlock_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && wr_to_ctrl) |-> $past(wel && rwel));
  assert_arr_needs_wel_R11: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && !wr_to_ctrl) |-> $past(wel && !prot));
  assert_commit_sets_busy_R6: assert property (@(posedge clk) disable iff (rst)
    nv_start |-> nv_busy);
  assert_strobe_implies_ack_R5: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> byte_ack);
endmodule

// File: rtl/wrprot_ctrl.sv
module wrprot_ctrl
  import wrprot_pkg::*;
#(
  parameter int AW        = 11,
  parameter int CTRL_DEF  = 20,
  parameter int MAX_BURST = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cold_boot,
  input  logic          bus_start,
  input  logic          bus_stop,
  input  logic          bus_addr_vld,
  input  logic [1:0]    bus_tgt,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr_vld,
  input  logic [7:0]    bus_wr_data,
  input  logic          bus_rd,
  input  logic          nv_done,
  input  logic [2:0]    bp_code,
  output logic          byte_ack,
  output logic          wr_stb,
  output logic          wr_to_ctrl,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          nv_start,
  output logic          nv_busy,
  output logic [7:0]    stat_q,
  output logic          rd_vld,
  output logic [7:0]    rd_data
);
  logic          wel, rwel, pf;
  logic          prot, apply, pf_clr;
  pend_e         pend;
  logic [AW-1:0] cur_addr;

  wrprot_guard #(.AW(AW)) i_guard (
    .bp_code (bp_code),
    .addr    (cur_addr),
    .prot    (prot)
  );

  wrprot_latch i_latch (
    .clk       (clk),
    .rst       (rst),
    .cold_boot (cold_boot),
    .apply     (apply),
    .pend      (pend),
    .nv_done   (nv_done),
    .pf_clr    (pf_clr),
    .wel       (wel),
    .rwel      (rwel),
    .pf        (pf)
  );

  wrprot_xfer #(.AW(AW), .CTRL_DEF(CTRL_DEF), .MAX_BURST(MAX_BURST)) i_xfer (
    .clk          (clk),
    .rst          (rst),
    .bus_start    (bus_start),
    .bus_stop     (bus_stop),
    .bus_addr_vld (bus_addr_vld),
    .bus_tgt      (bus_tgt),
    .bus_addr     (bus_addr),
    .bus_wr_vld   (bus_wr_vld),
    .bus_wr_data  (bus_wr_data),
    .nv_done      (nv_done),
    .wel          (wel),
    .rwel         (rwel),
    .prot         (prot),
    .cur_addr     (cur_addr),
    .apply        (apply),
    .pend         (pend),
    .pf_clr       (pf_clr),
    .byte_ack     (byte_ack),
    .wr_stb       (wr_stb),
    .wr_to_ctrl   (wr_to_ctrl),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .nv_start     (nv_start),
    .nv_busy      (nv_busy)
  );

  assign stat_q = {5'b0, rwel, wel, pf};

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_vld  <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_vld <= bus_rd;
      if (bus_rd) rd_data <= stat_q;
    end
  end

  assert_read_keeps_enables_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_stop && !nv_done && !bus_wr_vld) |=> (stat_q[2:1] == $past(stat_q[2:1])));
endmodule

// File: tb/test_wrprot_ctrl.sv
module test_wrprot_ctrl;
  logic        clk = 1'b0;
  logic        rst, cold_boot;
  logic        bus_start, bus_stop, bus_addr_vld, bus_wr_vld, bus_rd, nv_done;
  logic [1:0]  bus_tgt;
  logic [10:0] bus_addr;
  logic [7:0]  bus_wr_data;
  logic [2:0]  bp_code;
  logic        byte_ack, wr_stb, wr_to_ctrl, nv_start, nv_busy, rd_vld;
  logic [10:0] wr_addr;
  logic [7:0]  wr_data, stat_q, rd_data;

  always #2.5 clk = ~clk;

  wrprot_ctrl i_wrprot_ctrl (
    .clk(clk), .rst(rst), .cold_boot(cold_boot),
    .bus_start(bus_start), .bus_stop(bus_stop), .bus_addr_vld(bus_addr_vld),
    .bus_tgt(bus_tgt), .bus_addr(bus_addr), .bus_wr_vld(bus_wr_vld),
    .bus_wr_data(bus_wr_data), .bus_rd(bus_rd), .nv_done(nv_done), .bp_code(bp_code),
    .byte_ack(byte_ack), .wr_stb(wr_stb), .wr_to_ctrl(wr_to_ctrl), .wr_addr(wr_addr),
    .wr_data(wr_data), .nv_start(nv_start), .nv_busy(nv_busy), .stat_q(stat_q),
    .rd_vld(rd_vld), .rd_data(rd_data)
  );

  int compared = 0, mismatched = 0;
  bit finished = 0;

  // behavioural model state
  int m_wel, m_rwel, m_pf, m_busy, m_in, m_sel, m_cnt, m_any, m_pend, m_addr;
  int e_ack, e_we, e_isc, e_wa, e_wd, e_nvs, e_rdv, e_rd;

  function automatic int prot_of(int bp, int a);
    case (bp)
      2: return (a >= 'h600);
      3: return (a >= 'h400);
      4: return 1;
      5: return (a <= 'h03F);
      6: return (a <= 'h07F);
      7: return (a <= 'h0FF);
      default: return 0;
    endcase
  endfunction

  task automatic model_edge();
    int wel0, ok, d;
    wel0 = m_wel;
    e_ack = 0; e_we = 0; e_nvs = 0; e_rdv = 0;
    if (rst) begin
      m_wel = 0; m_rwel = 0; m_pf = cold_boot; m_busy = 0; m_in = 0; m_sel = 3;
      m_cnt = 0; m_any = 0; m_pend = -1; m_addr = 0;
      e_isc = 0; e_wa = 0; e_wd = 0; e_rd = 0;
      return;
    end
    if (bus_rd) begin e_rdv = 1; e_rd = m_rwel * 4 + m_wel * 2 + m_pf; end
    if (nv_done) m_busy = 0;
    if (bus_start) begin
      m_in = 1; m_sel = 3; m_cnt = 0; m_any = 0; m_pend = -1;
    end else if (bus_stop) begin
      if (m_in) begin
        if (m_pend == 0) begin m_wel = 0; m_rwel = 0; end
        if (m_pend == 2) begin m_wel = 1; m_rwel = 0; end
        if (m_pend == 6) begin m_rwel = wel0; m_wel = 1; end
        if (m_any) begin e_nvs = 1; m_busy = 1; end
      end
      m_in = 0; m_sel = 3; m_any = 0; m_pend = -1;
    end else if (bus_addr_vld && m_in) begin
      m_sel = bus_tgt; m_addr = bus_addr; m_cnt = 0;
    end else if (bus_wr_vld && m_in) begin
      d = bus_wr_data;
      ok = 0;
      if (m_sel == 0) ok = !m_busy && m_cnt == 0 && (d == 0 || d == 2 || d == 6);
      if (m_sel == 1) ok = !m_busy && m_wel && m_rwel && m_cnt < 8;
      if (m_sel == 2) ok = !m_busy && m_wel && !prot_of(bp_code, m_addr);
      if (ok) begin
        e_ack = 1; m_cnt++; e_isc = (m_sel == 1); e_wa = m_addr; e_wd = d;
        if (m_sel == 0) m_pend = d;
        if (m_sel == 1) begin m_any = 1; e_we = (m_addr < 20); if (m_addr < 20) m_pf = 0; end
        if (m_sel == 2) begin m_any = 1; e_we = 1; end
      end
      m_addr = (m_addr + 1) % 2048;
    end
    if (nv_done) begin m_busy = 0; m_rwel = 0; end
  endtask

  task automatic chk(string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", what, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("byte_ack R4 R8 R11 R12", byte_ack, e_ack);
    chk("wr_stb R5 R11", wr_stb, e_we);
    if (e_we) begin
      chk("wr_to_ctrl R5", wr_to_ctrl, e_isc);
      chk("wr_addr R5 R11", wr_addr, e_wa);
      chk("wr_data R4", wr_data, e_wd);
    end
    chk("nv_start R6", nv_start, e_nvs);
    chk("nv_busy R6 R7", nv_busy, m_busy);
    chk("status R1 R2 R3 R7 R10", stat_q, m_rwel * 4 + m_wel * 2 + m_pf);
    chk("rd_vld R9", rd_vld, e_rdv);
    chk("rd_data R9", rd_data, e_rd);
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
    bus_start = 0; bus_stop = 0; bus_addr_vld = 0; bus_wr_vld = 0; bus_rd = 0; nv_done = 0;
  endtask

  task automatic t_start(); bus_start = 1; tick(); endtask
  task automatic t_stop();  bus_stop = 1; tick(); endtask
  task automatic t_addr(int tg, int a); bus_addr_vld = 1; bus_tgt = 2'(tg); bus_addr = 11'(a); tick(); endtask
  task automatic t_byte(int d); bus_wr_vld = 1; bus_wr_data = 8'(d); tick(); endtask
  task automatic t_read(); bus_rd = 1; tick(); endtask
  task automatic t_done(); nv_done = 1; tick(); endtask
  task automatic stat_wr(int d); t_start(); t_addr(0, 0); t_byte(d); t_stop(); endtask
  task automatic unlock(); stat_wr(2); t_read(); stat_wr(6); endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      mismatched++; compared++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rst = 1; cold_boot = 1; bp_code = 0; bus_tgt = 3; bus_addr = 0; bus_wr_data = 0;
    bus_start = 0; bus_stop = 0; bus_addr_vld = 0; bus_wr_vld = 0; bus_rd = 0; nv_done = 0;
    @(negedge clk);
    tick(); tick();            // R1 reset state
    rst = 0; cold_boot = 0;
    tick();
    // R4 control write with no enables: ignored; R11 array write ignored
    t_start(); t_addr(1, 3); t_byte('h55); t_stop();
    t_start(); t_addr(2, 'h10); t_byte('h11); t_stop();
    // R12 byte without target
    t_start(); t_byte('h02); t_addr(3, 0); t_byte('h02); t_stop();
    // R2 0x06 with WEL clear sets only WEL
    stat_wr(6); t_read();
    // R3 clear, illegal value, second byte, restart abort
    stat_wr(0);
    stat_wr('h0A);
    stat_wr('h86);
    t_start(); t_addr(0, 0); t_byte(2); t_byte(2); t_start(); t_stop();
    // R2 proper unlock with a read in between (R9)
    unlock(); t_read();
    stat_wr(0); unlock();
    // R5 R10 control burst, then abort: RWEL kept (R6)
    t_start(); t_addr(1, 2); t_byte('hA1); t_byte('hA2); t_byte('hA3); t_start(); t_stop();
    t_read();
    // R4 R5 burst past limit across defined edge, commit (R6)
    t_start(); t_addr(1, 16);
    for (int i = 0; i < 9; i++) t_byte('hC0 + i);
    t_stop();
    // R8 traffic while busy
    t_start(); t_addr(2, 'h20); t_byte('h77); t_stop();
    stat_wr(0);
    t_read(); tick(); tick();
    t_done();                  // R7
    t_start(); t_addr(1, 0); t_byte('h99); t_stop();  // R4 WEL only
    // R11 array sweep across protect codes
    for (int bp = 0; bp < 8; bp++) begin
      int pts[10] = '{'h000, 'h03F, 'h040, 'h07F, 'h0FF, 'h100, 'h3FF, 'h400, 'h5FF, 'h600};
      bp_code = 3'(bp);
      for (int k = 0; k < 10; k++) begin
        t_start(); t_addr(2, pts[k]); t_byte(pts[k] & 'hFF); t_stop(); t_done();
      end
      t_start(); t_addr(2, 'h7FF); t_byte('h3C); t_byte('h3D); t_stop(); t_done();
    end
    // R11 burst crossing a range edge
    bp_code = 2;
    t_start(); t_addr(2, 'h5FE); t_byte(1); t_byte(2); t_byte(3); t_stop(); t_done();
    bp_code = 0;
    stat_wr(0); t_read(); tick();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule